// File: doc/BRIEF.md
# Nonvolatile Memory Pulse Timing Front End

This block sits between the bus and the command sequencer of an on-chip nonvolatile memory. Software sets a divisor once after reset. From then on the block divides the bus clock into a slow timing tick. The divisor should be chosen so that the tick falls between 150 kHz and 200 kHz. With a 5 µs tick, every tick count maps directly to an absolute time.

A program or erase command arrives as a start strobe with a requested tick count. The block accepts the command only when the divider has been configured and no pulse is already running. When it accepts a command, it restarts the tick phase and times the pulse as a whole number of tick periods. It then signals completion with a one-cycle strobe.

A refused command raises a sticky access-error flag, which software clears by writing 1. While that flag is set, the block also refuses the divisor write.

The pulse sequencer has three states:
- `ST_IDLE` waits for a command.
- `ST_RUN` counts ticks.
- `ST_DONE` lasts one cycle and raises the completion strobe.

Its transitions are:
- *accept-count*: `ST_IDLE`→`ST_RUN` when the count is non-zero.
- *accept-zero*: `ST_IDLE`→`ST_DONE` when the count is zero.
- *last-tick*: `ST_RUN`→`ST_DONE` on the tick that brings the remaining count from 1 to 0.
- *retire*: `ST_DONE`→`ST_IDLE` unconditionally.

Top module: `nvm_tick_timer`

## Requirements
- R1: After reset, `div_loaded`, `div_value`, `acc_err`, `busy`, `tick` and `pulse_done` are all 0.
- R2: While `div_loaded` is 0, `cmd_start` is refused: `cmd_accept` stays 0, `busy` stays 0, and `acc_err` is 1 from the next cycle on.
- R3: The first `cfg_wr` with `acc_err` at 0 stores `cfg_data` into `div_value` and sets `div_loaded` from the next cycle until reset. All later writes leave `div_value` unchanged.
- R4: A `cfg_wr` in a cycle where `acc_err` is 1 is refused and `div_loaded` stays 0. After the flag is cleared, a write is accepted.
- R5: `tick` is never high while `div_loaded` is 0. Once loaded and with no command accepted, `tick` is a one-cycle strobe repeating every D+1 bus cycles, where D is `div_value`.
- R6: A command is accepted (`cmd_accept` high) when `cmd_start` is high, `div_loaded` is 1 and `busy` is 0. `busy` is high from the cycle after acceptance. The tick phase restarts, so with a count N ≥ 1, `pulse_done` is high exactly N·(D+1) cycles after the acceptance edge.
- R7: `cmd_start` while `busy` is 1 is refused and sets `acc_err` on the next cycle. The pulse in progress keeps its original completion time.
- R8: `pulse_done` is high for exactly one cycle, and `busy` is 0 in the cycle after it. A command with N = 0 shows `pulse_done` in the first cycle after acceptance.
- R9: `err_clr` high clears `acc_err` on the next cycle. If a refused `cmd_start` occurs in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Divisor write strobe |
| cfg_data | input | 6 | Divisor value to write |
| err_clr | input | 1 | Write-1 clear of the access-error flag |
| cmd_start | input | 1 | Command start strobe |
| cmd_ticks | input | 8 | Pulse length in tick periods |
| div_value | output | 6 | Stored divisor |
| div_loaded | output | 1 | Divisor has been configured |
| acc_err | output | 1 | Sticky access-error flag |
| tick | output | 1 | One-cycle timing tick strobe |
| cmd_accept | output | 1 | Command taken this cycle |
| busy | output | 1 | Pulse in progress |
| pulse_done | output | 1 | One-cycle completion strobe |

## Verification
The following properties are checked in every cycle:
- The stored divisor and its lock never change once set.
- No tick appears before the divisor is loaded, and the tick counter never exceeds the divisor.
- No command is accepted, and the sequencer is never busy, without a loaded divisor.
- A refused start while busy raises the error flag.
- The done strobe never lasts two cycles.

Some behaviours can only be shown by the bench scenarios. These are the exact tick spacing for each divisor and the N·(D+1) completion latency for random divisors and counts. They also include the refusal-then-retry sequence around the error flag and the set-over-clear priority.

// File: rtl/nvm_timer_pkg.sv
package nvm_timer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } pulse_state_t;
endpackage

// File: rtl/nvm_div_reg.sv
module nvm_div_reg #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wr_data,
    input  logic             err_flag,
    output logic [DIV_W-1:0] div_q,
    output logic             loaded_q
);
    logic wr_ok;

    // A write lands only once, and only while no access error is pending
    assign wr_ok = wr_en && !loaded_q && !err_flag;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q    <= '0;
            loaded_q <= 1'b0;
        end else if (wr_ok) begin
            div_q    <= wr_data;
            loaded_q <= 1'b1;
        end
    end

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        loaded_q |=> (loaded_q && $stable(div_q))); // R3
    AST_ERR_BLOCKS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !loaded_q) |=> !loaded_q); // R4
endmodule

// File: rtl/nvm_tick_gen.sv
module nvm_tick_gen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             restart,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    assign wrap = (cnt_q == divisor);
    assign tick = enable && wrap;

    always_ff @(posedge clk) begin
        if (!rst_n || !enable || restart) begin
            cnt_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !tick); // R5
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> (cnt_q <= divisor)); // R5
endmodule

// File: rtl/nvm_pulse_fsm.sv
module nvm_pulse_fsm
    import nvm_timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             loaded,
    input  logic             tick,
    input  logic             cmd_start,
    input  logic [CNT_W-1:0] cmd_ticks,
    input  logic             err_clr,
    output logic             cmd_accept,
    output logic             busy,
    output logic             pulse_done,
    output logic             err_q
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    pulse_state_t     state_q, state_d;
    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_start && loaded)
                         state_d = (cmd_ticks == '0) ? ST_DONE : ST_RUN;
            ST_RUN:  if (tick && remain_q == LAST) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cmd_accept = 1'b0;
        busy       = 1'b0;
        pulse_done = 1'b0;
        unique case (state_q)
            ST_IDLE: cmd_accept = cmd_start && loaded;
            ST_RUN:  busy = 1'b1;
            ST_DONE: begin
                busy       = 1'b1;
                pulse_done = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (cmd_accept) begin
            remain_q <= cmd_ticks;
        end else if (state_q == ST_RUN && tick) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    // Sticky error: a refused start wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (cmd_start && !cmd_accept) begin
            err_q <= 1'b1;
        end else if (err_clr) begin
            err_q <= 1'b0;
        end
    end

    AST_NO_ACCEPT_UNLOADED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_accept |-> loaded); // R2
    AST_BUSY_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> loaded); // R6
    AST_BUSY_START_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_start) |=> err_q); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_done |=> !pulse_done); // R8
endmodule

// File: rtl/nvm_tick_timer.sv
module nvm_tick_timer #(
    parameter int DIV_W = 6,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [DIV_W-1:0] cfg_data,
    input  logic             err_clr,
    input  logic             cmd_start,
    input  logic [CNT_W-1:0] cmd_ticks,
    output logic [DIV_W-1:0] div_value,
    output logic             div_loaded,
    output logic             acc_err,
    output logic             tick,
    output logic             cmd_accept,
    output logic             busy,
    output logic             pulse_done
);
    nvm_div_reg #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr),
        .wr_data  (cfg_data),
        .err_flag (acc_err),
        .div_q    (div_value),
        .loaded_q (div_loaded)
    );

    nvm_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (div_loaded),
        .restart (cmd_accept),
        .divisor (div_value),
        .tick    (tick)
    );

    nvm_pulse_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .loaded     (div_loaded),
        .tick       (tick),
        .cmd_start  (cmd_start),
        .cmd_ticks  (cmd_ticks),
        .err_clr    (err_clr),
        .cmd_accept (cmd_accept),
        .busy       (busy),
        .pulse_done (pulse_done),
        .err_q      (acc_err)
    );

    AST_UNLOADED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !div_loaded |-> (!busy && !tick && !pulse_done)); // R2
endmodule

// File: tb/sim_nvm_tick_timer.sv
`timescale 1ns/1ps
module sim_nvm_tick_timer;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_wr, err_clr, cmd_start;
    logic [5:0] cfg_data;
    logic [7:0] cmd_ticks;
    logic [5:0] div_value;
    logic       div_loaded, acc_err, tick, cmd_accept, busy, pulse_done;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    nvm_tick_timer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .err_clr(err_clr), .cmd_start(cmd_start), .cmd_ticks(cmd_ticks),
        .div_value(div_value), .div_loaded(div_loaded), .acc_err(acc_err),
        .tick(tick), .cmd_accept(cmd_accept), .busy(busy), .pulse_done(pulse_done)
    );

    function automatic int exp_period(int d);
        return d + 1;
    endfunction

    function automatic int exp_latency(int n, int d);
        return (n == 0) ? 0 : n * (d + 1);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cfg_wr = 0; err_clr = 0; cmd_start = 0;
        cfg_data = '0; cmd_ticks = '0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic load_div(int d);
        cfg_wr = 1; cfg_data = 6'(d);
        step();
        cfg_wr = 0;
    endtask

    task automatic measure_tick(int d);
        int k = 0;
        while (!tick && k < 200) begin step(); k++; end
        step();
        k = 1;
        while (!tick && k < 200) begin step(); k++; end
        check(k == exp_period(d), "R5 tick period", k, exp_period(d));
    endtask

    // Issue a command; optionally inject a start at cycle index intrude
    task automatic run_cmd(int n, int d, int intrude);
        int k = 0;
        int exp = exp_latency(n, d);
        cmd_ticks = 8'(n); cmd_start = 1;
        #0;
        check(cmd_accept == 1, "R6 accept", int'(cmd_accept), 1);
        step();
        cmd_start = 0;
        check(busy == 1, "R6 busy after accept", int'(busy), 1);
        while (!pulse_done && k < 2000) begin
            if (k == intrude) cmd_start = 1;
            step();
            if (k == intrude) begin
                cmd_start = 0;
                check(acc_err == 1, "R7 start while busy", int'(acc_err), 1);
            end
            k++;
        end
        check(k == exp, (n == 0) ? "R8 zero count latency" : "R6 done latency", k, exp);
        step();
        check(pulse_done == 0, "R8 done one cycle", int'(pulse_done), 0);
        check(busy == 0, "R8 busy drops", int'(busy), 0);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        do_reset();
        check({div_loaded, acc_err, busy, tick, pulse_done} == 5'b0, "R1 reset flags",
              int'({div_loaded, acc_err, busy, tick, pulse_done}), 0);
        check(div_value == 0, "R1 reset divisor", int'(div_value), 0);

        // R2: refused command before load
        cmd_start = 1; cmd_ticks = 8'd3; #0;
        check(cmd_accept == 0, "R2 no accept", int'(cmd_accept), 0);
        step(); cmd_start = 0;
        check(acc_err == 1, "R2 error set", int'(acc_err), 1);
        check(busy == 0, "R2 not busy", int'(busy), 0);

        // R9: refused start beats clear
        cmd_start = 1; err_clr = 1; step(); cmd_start = 0; err_clr = 0;
        check(acc_err == 1, "R9 set wins", int'(acc_err), 1);

        // R4: write refused while flag set
        load_div(5);
        check(div_loaded == 0, "R4 write refused", int'(div_loaded), 0);
        check(tick == 0, "R5 no tick unloaded", int'(tick), 0);
        err_clr = 1; step(); err_clr = 0;
        check(acc_err == 0, "R9 cleared", int'(acc_err), 0);

        // R3: single write accepted, second ignored
        load_div(2);
        check(div_loaded == 1 && div_value == 2, "R3 first write", int'(div_value), 2);
        load_div(9);
        check(div_value == 2, "R3 second write ignored", int'(div_value), 2);
        measure_tick(2);
        run_cmd(3, 2, -1);
        run_cmd(0, 2, -1);
        run_cmd(4, 2, 3);
        check(div_value == 2 && div_loaded, "R3 lock persists", int'(div_value), 2);

        // Directed extremes of the divisor
        do_reset(); load_div(0); measure_tick(0); run_cmd(5, 0, -1);
        do_reset(); load_div(63); measure_tick(63); run_cmd(2, 63, 10);

        // Random divisors and counts
        for (int it = 0; it < 8; it++) begin
            int d = $urandom % 12;
            do_reset();
            load_div(d);
            check(div_value == 6'(d), "R3 random load", int'(div_value), d);
            measure_tick(d);
            for (int j = 0; j < 4; j++) begin
                int n = $urandom % 7;
                int intr = ($urandom % 3 == 0 && n > 1) ? 1 : -1;
                run_cmd(n, d, intr);
                if (acc_err) begin err_clr = 1; step(); err_clr = 0; end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule